// File: doc/BRIEF.md
# Per-Line Residency Length Profiler

This block shadows a small direct-mapped cache that holds tags only. Each line carries a reference counter. The counter measures how many loads and stores one residency serves, from the access that brings a block into the line until the block leaves it. The caller supplies one byte address per cycle with a valid strobe. The block returns a stream of finished residency lengths, each tagged with the line that produced it.

A block leaves its line in one of two ways. A reference to a different block that maps to the same line evicts it. A flush request also ends it. The flush visits every line in turn and reports whatever is still resident. One memory block can produce many residencies in a run, one for each time it is brought back after an eviction.

Two running totals are kept so that the count of residencies can be compared with the mass of references they served. The totals are the number of lengths reported and the sum of those lengths.

Top module: `residency_profiler`

## Requirements
- R1: While reset is held and right after it, no length is reported, both totals read zero, and `flush_busy` and `flush_done` are low.
- R2: The access that places a block in a line counts as its first reference, so a new residency starts at 1. Each later hit to the same block adds 1.
- R3: The line index is the byte address modulo CACHE_BYTES divided by LINE_BYTES. With the default 8-bit address, 2-byte lines and two lines, the index is address bit 1 and the tag is bits 7..2.
- R4: A reference whose tag differs from the tag in a valid line evicts that line. The old count appears on `len_value`, with `len_line` equal to the line index, in the cycle after the reference. The new block starts its own residency at 1.
- R5: A reference that lands in an invalid line reports nothing.
- R6: A line counter holds at 2^CNT_W-1 and does not wrap.
- R7: With each reported length, `resid_count` rises by one and `ref_mass` rises by that length. Both change in the same cycle that `len_valid` is high, and at no other time.
- R8: A flush request accepted while idle starts a walk on the next cycle. The walk handles one line per cycle in ascending index order. A valid line reports its count and index and is then invalidated. An invalid line reports nothing.
- R9: `flush_busy` is high during the walk. `flush_done` rises in the cycle the last line's result is visible. It stays high until the next accepted reference or flush request.
- R10: During a walk, references and further flush requests are ignored. A block referenced during the walk is therefore absent afterwards, and its next reference starts a fresh residency without an eviction.
- R11: A reference in the same cycle as an accepted flush request is handled first. Any eviction it causes is reported before the walk, and its count is included in what the walk reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | A memory reference is present |
| ref_addr | input | ADDR_W | Byte address of the reference |
| flush_req | input | 1 | Request to report and clear all lines |
| len_valid | output | 1 | A residency length is reported this cycle |
| len_value | output | CNT_W | Length of the finished residency |
| len_line | output | log2(lines) | Line that held the residency |
| flush_busy | output | 1 | Flush walk in progress |
| flush_done | output | 1 | Flush walk finished |
| resid_count | output | TOT_W | Number of residencies reported |
| ref_mass | output | TOT_W | Sum of reported lengths |

## Verification
Two events can fall in the same cycle: a reference that evicts a line, and a flush request. The bench provokes this by raising `flush_req` together with a conflicting reference, and again together with a hit. It expects the eviction to be reported first and the refreshed count to appear during the walk. It also sends references and a second flush request while the walk is running, to confirm they leave no trace. A behavioural model of lines, counters and totals is stepped every clock, and each cycle's outputs are compared against it.

// File: rtl/residency_profiler.sv
module residency_profiler #(
  parameter int ADDR_W      = 8,
  parameter int CACHE_BYTES = 4,
  parameter int LINE_BYTES  = 2,
  parameter int CNT_W       = 8,
  parameter int TOT_W       = 24
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               ref_valid,
  input  logic [ADDR_W-1:0]                  ref_addr,
  input  logic                               flush_req,
  output logic                               len_valid,
  output logic [CNT_W-1:0]                   len_value,
  output logic [$clog2(CACHE_BYTES/LINE_BYTES)-1:0] len_line,
  output logic                               flush_busy,
  output logic                               flush_done,
  output logic [TOT_W-1:0]                   resid_count,
  output logic [TOT_W-1:0]                   ref_mass
);
  localparam int NLINES = CACHE_BYTES / LINE_BYTES;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(NLINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [IDX_W-1:0] LAST    = IDX_W'(NLINES - 1);

  logic [NLINES-1:0] vld;
  logic [TAG_W-1:0]  tag_q [NLINES];
  logic [CNT_W-1:0]  cnt_q [NLINES];
  logic              flushing;
  logic [IDX_W-1:0]  ptr;

  wire [IDX_W-1:0] idx    = ref_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] rtag   = ref_addr[ADDR_W-1 -: TAG_W];
  wire             accept = ref_valid && !flushing;
  wire             hit    = vld[idx] && (tag_q[idx] == rtag);
  wire             evict  = accept && vld[idx] && !hit;
  wire             femit  = flushing && vld[ptr];
  wire             emit   = evict || femit;
  wire [CNT_W-1:0] ev_val = flushing ? cnt_q[ptr] : cnt_q[idx];
  wire [IDX_W-1:0] ev_ln  = flushing ? ptr : idx;

  assign flush_busy = flushing;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld         <= '0;
      flushing    <= 1'b0;
      ptr         <= '0;
      flush_done  <= 1'b0;
      len_valid   <= 1'b0;
      len_value   <= '0;
      len_line    <= '0;
      resid_count <= '0;
      ref_mass    <= '0;
      for (int i = 0; i < NLINES; i++) begin
        tag_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else begin
      len_valid <= emit;
      if (emit) begin
        len_value   <= ev_val;
        len_line    <= ev_ln;
        resid_count <= resid_count + 1'b1;
        ref_mass    <= ref_mass + TOT_W'(ev_val);
      end
      if (flushing) begin
        vld[ptr] <= 1'b0;
        ptr      <= ptr + 1'b1;
        if (ptr == LAST) begin
          flushing   <= 1'b0;
          flush_done <= 1'b1;
        end
      end else begin
        if (accept) begin
          flush_done <= 1'b0;
          if (hit) begin
            cnt_q[idx] <= (cnt_q[idx] == CNT_MAX) ? CNT_MAX : cnt_q[idx] + 1'b1;
          end else begin
            vld[idx]   <= 1'b1;
            tag_q[idx] <= rtag;
            cnt_q[idx] <= CNT_W'(1);
          end
        end
        if (flush_req) begin
          flushing   <= 1'b1;
          ptr        <= '0;
          flush_done <= 1'b0;
        end
      end
    end
  end

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    len_valid |-> (len_value != '0)); // R2

  AST_EVICT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (len_valid && !$past(flushing)) |-> $past(ref_valid)); // R4

  AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (resid_count != $past(resid_count)) |-> len_valid); // R7

  AST_DONE_AFTER_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_done) |-> $past(flushing)); // R9

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush_busy && flush_done)); // R9

  AST_WALK_NO_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |=> ($countones(vld) <= $countones($past(vld)))); // R10
endmodule

// File: tb/sim_residency_profiler.sv
`timescale 1ns/1ps
module sim_residency_profiler;
  localparam int NL = 2;
  localparam int MAXC = 255;

  logic clk = 0, rst_n = 0, ref_valid = 0, flush_req = 0;
  logic [7:0] ref_addr = '0;
  logic len_valid, flush_busy, flush_done;
  logic [7:0] len_value;
  logic [0:0] len_line;
  logic [23:0] resid_count, ref_mass;

  always #4 clk = ~clk;

  residency_profiler u0 (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_addr(ref_addr),
    .flush_req(flush_req), .len_valid(len_valid), .len_value(len_value),
    .len_line(len_line), .flush_busy(flush_busy), .flush_done(flush_done),
    .resid_count(resid_count), .ref_mass(ref_mass));

  int tests = 0, fails = 0;
  bit finished = 0;
  string req = "R1";

  int mv[NL], mt[NL], mc[NL];
  bit mflush = 0, mdone = 0;
  int mptr = 0, mcount = 0, mmass = 0;
  bit e_lv; int e_val, e_line;

  task automatic chk(string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic emit(int v, int l);
    e_lv = 1; e_val = v; e_line = l; mcount++; mmass += v;
  endtask

  task automatic step(bit rv, int a, bit fr);
    ref_valid = rv; ref_addr = 8'(a); flush_req = fr;
    e_lv = 0;
    if (mflush) begin
      if (mv[mptr] != 0) emit(mc[mptr], mptr);
      mv[mptr] = 0;
      if (mptr == NL - 1) begin mflush = 0; mdone = 1; end
      else mptr++;
    end else begin
      if (rv) begin
        int i, t;
        i = (a % 4) / 2; t = a / 4;
        mdone = 0;
        if (mv[i] != 0 && mt[i] == t) mc[i] = (mc[i] < MAXC) ? mc[i] + 1 : MAXC;
        else begin
          if (mv[i] != 0) emit(mc[i], i);
          mv[i] = 1; mt[i] = t; mc[i] = 1;
        end
      end
      if (fr) begin mflush = 1; mptr = 0; mdone = 0; end
    end
    @(posedge clk); @(negedge clk);
    chk("len_valid", len_valid, e_lv);
    if (e_lv) begin
      chk("len_value", len_value, e_val);
      chk("len_line", len_line, e_line);
    end
    chk("resid_count", resid_count, mcount);
    chk("ref_mass", ref_mass, mmass);
    chk("flush_busy", flush_busy, mflush);
    chk("flush_done", flush_done, mdone);
    ref_valid = 0; flush_req = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL %s watchdog actual=running expected=finished", req);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) begin mv[i] = 0; mt[i] = 0; mc[i] = 0; end
    repeat (3) @(negedge clk);
    req = "R1";
    chk("len_valid in reset", len_valid, 0);
    chk("resid_count in reset", resid_count, 0);
    chk("ref_mass in reset", ref_mass, 0);
    chk("flush_busy in reset", flush_busy, 0);
    rst_n = 1;
    step(0, 0, 0);

    req = "R5";
    step(1, 0, 0); step(1, 2, 0);
    req = "R2";
    step(1, 1, 0); step(1, 3, 0); step(1, 0, 0);
    req = "R3";
    step(1, 5, 0); step(1, 7, 0); step(1, 6, 0);
    req = "R4";
    step(1, 4, 0); step(1, 0, 0); step(1, 10, 0); step(1, 2, 0);

    req = "R6";
    step(1, 8, 0);
    for (int k = 0; k < 300; k++) step(1, 9, 0);
    step(1, 12, 0);

    req = "R11";
    step(1, 16, 1);
    step(1, 3, 0);
    req = "R8";
    step(0, 0, 0);
    req = "R9";
    step(0, 0, 0); step(0, 0, 0);

    req = "R11";
    step(1, 20, 0); step(1, 20, 1);
    req = "R10";
    step(1, 22, 1); step(1, 24, 1);
    step(0, 0, 0); step(1, 22, 0); step(1, 24, 0);

    req = "R8";
    step(0, 0, 1); step(0, 0, 0); step(0, 0, 0);
    step(0, 0, 1); step(0, 0, 0); step(0, 0, 0);

    req = "R7";
    for (int k = 0; k < 400; k++)
      step(($urandom % 4) != 0, $urandom % 32, ($urandom % 40) == 0);
    step(0, 0, 1); step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule